// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Deserializer

This block takes four serial audio lines, each carrying one stereo pair, and turns them into eight parallel 24-bit samples per frame. It runs on the bit clock. The word clock enters as a data signal and is synchronized and edge-detected inside the block. Every half of the word clock spans 32 bit-clock periods. The first half of a frame carries the left (odd) channel and the second half carries the right (even) channel.

A 4-bit format code picks the word length (16, 18, 20, 22 or 24 bits) and the justification within the half period. One code mutes the outputs, and several codes are reserved. A polarity input selects whether a rising or a falling word-clock edge opens a frame. Four user bits are captured on the edge that closes each frame. When the right half completes, a single-cycle strobe marks the moment at which all eight samples and the user bits change together.

Top module: `serial_audio_deser`

## Requirements
- R1: `fmtCode` selects the word format. Codes 0, 1, 2 and 3 give right-justified words of 16, 18, 20 and 22 bits. Codes 4, 5, 6 and 7 give left-justified words of the same four lengths. Code 12 gives right-justified 24-bit words and code 13 gives left-justified 24-bit words. Each output sample holds the word with its MSB at bit 23, and the unused low bits are zero.
- R2: In left-justified formats the word MSB is the first bit of the half period, and the bits after the word are ignored. In right-justified formats the word LSB is the last bit of the half period, and the bits before the word are ignored.
- R3: Code 15 (mute) and the reserved codes 8, 9, 10, 11 and 14 force all eight samples of the frame to zero. The frame strobe still fires and the user bits are still captured.
- R4: When `startOnFall` is 1, a falling `wordClk` edge opens a frame. When it is 0, a rising edge opens it. The half that follows the opening edge is the left channel.
- R5: Line k (k = 0 to 3) feeds channel 2k (left) and channel 2k+1 (right). Channel c occupies `samplesOut[24*c+23 : 24*c]`.
- R6: `userOut` takes the value `userIn` had in the bit period in which the frame-opening edge that ends the right half appears. It is presented with that frame's samples.
- R7: `frameValid` is high for exactly one cycle per completed frame. `samplesOut` and `userOut` change only on the edge that raises it.
- R8: The active-low reset clears the samples, the user bits, the strobe and the edge history. No frame is reported until a frame-opening edge has been seen and a full left half has followed it.
- R9: The format code is taken at each frame-opening edge and applies to both halves of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| wordClk | input | 1 | Word clock, 32 bit periods per half |
| startOnFall | input | 1 | 1: falling edge opens a frame; 0: rising edge |
| fmtCode | input | 4 | Format select code |
| dataIn | input | 4 | Serial data, one line per stereo pair |
| userIn | input | 4 | User bits, captured once per frame |
| frameValid | output | 1 | One-cycle strobe when a frame's samples update |
| samplesOut | output | 192 | Eight 24-bit samples, channel c at bits 24c+23..24c |
| userOut | output | 4 | User bits of the last reported frame |

## Verification
The bench sends frames of pseudo-random words in every valid format. It changes the format each frame and fills the unused bit positions with a toggling pattern, so that a shift by one position, a missed ignore of leading or trailing bits, or a right half decoded with the next frame's format all produce wrong samples. Mute and reserved codes are sent between normal frames to show that zero forcing and user capture follow the code. A second run with the opposite word-clock polarity starts mid-frame after reset, which separates a correct first-edge rule from one that reports a partial frame.

// File: rtl/aud_deser_pkg.sv
package aud_deser_pkg;

  // Strobes from control to datapath, all aligned with the synchronized word clock
  typedef struct packed {
    logic frameStart;    // frame-opening edge seen
    logic captureLeft;   // left half just completed
    logic captureRight;  // right half just completed, frame done
  } deserStrobes_t;

  typedef struct packed {
    logic       leftJust;
    logic       mute;
    logic [4:0] width;
  } fmtInfo_t;

  function automatic fmtInfo_t decodeFmt(input logic [3:0] code);
    fmtInfo_t info;
    info.leftJust = 1'b0;
    info.mute     = 1'b0;
    info.width    = 5'd24;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3: info.width = 5'd16 + {2'b00, code[1:0], 1'b0};
      4'd4, 4'd5, 4'd6, 4'd7: begin
        info.width    = 5'd16 + {2'b00, code[1:0], 1'b0};
        info.leftJust = 1'b1;
      end
      4'd12: info.width = 5'd24;
      4'd13: info.leftJust = 1'b1;
      default: info.mute = 1'b1;  // mute and reserved codes
    endcase
    return info;
  endfunction

endpackage

// File: rtl/aud_deser_ctrl.sv
module aud_deser_ctrl
  import aud_deser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wordClk,
  input  logic          startOnFall,
  output deserStrobes_t strobes,
  output logic          frameValid
);

  logic [SYNC_STAGES-1:0] wcSync;
  logic wcPrev, wcNow;
  logic riseDet, fallDet, startEdge, endEdge;
  logic seenStart, haveLeft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcSync <= '0;
      wcPrev <= 1'b0;
    end else begin
      wcSync <= {wcSync[SYNC_STAGES-2:0], wordClk};
      wcPrev <= wcSync[SYNC_STAGES-1];
    end
  end

  assign wcNow     = wcSync[SYNC_STAGES-1];
  assign riseDet   = wcNow & ~wcPrev;
  assign fallDet   = ~wcNow & wcPrev;
  assign startEdge = startOnFall ? fallDet : riseDet;
  assign endEdge   = startOnFall ? riseDet : fallDet;

  assign strobes.frameStart   = startEdge;
  assign strobes.captureLeft  = endEdge & seenStart;
  assign strobes.captureRight = startEdge & haveLeft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenStart  <= 1'b0;
      haveLeft   <= 1'b0;
      frameValid <= 1'b0;
    end else begin
      seenStart  <= seenStart | startEdge;
      if (strobes.captureLeft)
        haveLeft <= 1'b1;
      else if (startEdge)
        haveLeft <= 1'b0;
      frameValid <= strobes.captureRight;
    end
  end

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |=> !frameValid);

endmodule

// File: rtl/aud_deser_datapath.sv
module aud_deser_datapath
  import aud_deser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int USER_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  deserStrobes_t                       strobes,
  input  logic [3:0]                          fmtCode,
  input  logic [LANES-1:0]                    dataIn,
  input  logic [USER_W-1:0]                   userIn,
  output logic [2*LANES-1:0][SAMPLE_W-1:0]    sampleReg,
  output logic [USER_W-1:0]                   userOut
);

  localparam int PIPE_W = 4 + USER_W + LANES;
  localparam int CHANS  = 2 * LANES;

  // Delay inputs by the word-clock synchronizer depth so they stay aligned
  logic [SYNC_STAGES-1:0][PIPE_W-1:0] inPipe;
  logic [3:0]          fmtNow;
  logic [USER_W-1:0]   userNow;
  logic [LANES-1:0]    dataNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inPipe <= '0;
    else        inPipe <= {inPipe[SYNC_STAGES-2:0], {fmtCode, userIn, dataIn}};
  end

  assign {fmtNow, userNow, dataNow} = inPipe[SYNC_STAGES-1];

  logic [3:0] fmtReg;
  fmtInfo_t   curFmt;
  assign curFmt = decodeFmt(fmtReg);

  logic [LANES-1:0][SLOT_W-1:0]   slotShift;
  logic [LANES-1:0][SAMPLE_W-1:0] leftHold;
  logic [SAMPLE_W-1:0]            aligned [LANES];

  function automatic logic [SAMPLE_W-1:0] alignWord(input logic [SLOT_W-1:0] slot,
                                                    input fmtInfo_t info);
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] mask;
    mask = {SAMPLE_W{1'b1}} << (SAMPLE_W - int'(info.width));
    if (info.leftJust) raw = slot[SLOT_W-1 -: SAMPLE_W];
    else               raw = slot[SAMPLE_W-1:0] << (SAMPLE_W - int'(info.width));
    return info.mute ? '0 : (raw & mask);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign aligned[l] = alignWord(slotShift[l], curFmt);

    // R3
    mute_right_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes.captureRight && curFmt.mute) |=> (sampleReg[2*l+1] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotShift <= '0;
      leftHold  <= '0;
      sampleReg <= '0;
      userOut   <= '0;
      fmtReg    <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        slotShift[l] <= {slotShift[l][SLOT_W-2:0], dataNow[l]};
      if (strobes.captureLeft)
        for (int l = 0; l < LANES; l++) leftHold[l] <= aligned[l];
      if (strobes.captureRight) begin
        for (int l = 0; l < LANES; l++) begin
          sampleReg[2*l]   <= leftHold[l];
          sampleReg[2*l+1] <= aligned[l];
        end
        userOut <= userNow;
      end
      if (strobes.frameStart)
        fmtReg <= fmtNow;
    end
  end

  // R7
  samples_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.captureRight |=> $stable(sampleReg));

  // R6
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.captureRight |=> $stable(userOut));

  initial begin
    // R5
    lane_count_chk: assert (CHANS == 2 * LANES && SLOT_W >= SAMPLE_W && SYNC_STAGES >= 2);
  end

endmodule

// File: rtl/serial_audio_deser.sv
module serial_audio_deser
  import aud_deser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int USER_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wordClk,
  input  logic                          startOnFall,
  input  logic [3:0]                    fmtCode,
  input  logic [LANES-1:0]              dataIn,
  input  logic [USER_W-1:0]             userIn,
  output logic                          frameValid,
  output logic [2*LANES*SAMPLE_W-1:0]   samplesOut,
  output logic [USER_W-1:0]             userOut
);

  deserStrobes_t strobes;
  logic [2*LANES-1:0][SAMPLE_W-1:0] sampleReg;

  aud_deser_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wordClk     (wordClk),
    .startOnFall (startOnFall),
    .strobes     (strobes),
    .frameValid  (frameValid)
  );

  aud_deser_datapath #(
    .LANES       (LANES),
    .SAMPLE_W    (SAMPLE_W),
    .SLOT_W      (SLOT_W),
    .USER_W      (USER_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .fmtCode   (fmtCode),
    .dataIn    (dataIn),
    .userIn    (userIn),
    .sampleReg (sampleReg),
    .userOut   (userOut)
  );

  assign samplesOut = sampleReg;

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameValid |-> $stable(userOut));

endmodule

// File: tb/serial_audio_deser_test.sv
module serial_audio_deser_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wordClk = 1'b0;
  logic         startOnFall = 1'b0;
  logic [3:0]   fmtCode = 4'd0;
  logic [3:0]   dataIn = 4'd0;
  logic [3:0]   userIn = 4'd0;
  logic         frameValid;
  logic [191:0] samplesOut;
  logic [3:0]   userOut;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [191:0] smp;
    logic [3:0]   usr;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  logic         pendValid = 1'b0;
  logic [191:0] pendSamples = '0;
  string        pendTag = "";
  logic [31:0]  seed = 32'h1234_5678;
  logic         wasValid = 1'b0;
  logic [191:0] lastSamples = '0;
  logic [3:0]   lastUser = '0;

  always #4 clk = ~clk;  // 125 MHz

  serial_audio_deser uut (
    .clk(clk), .rst_n(rst_n), .wordClk(wordClk), .startOnFall(startOnFall),
    .fmtCode(fmtCode), .dataIn(dataIn), .userIn(userIn),
    .frameValid(frameValid), .samplesOut(samplesOut), .userOut(userOut)
  );

  task automatic check(input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: one full frame (left then right half), pushes the previous frame's expectation
  task automatic sendFrame(input logic [3:0] fmt, input logic [3:0] usr,
                           input logic reportIt, input string tag);
    int  n;
    logic lj, mute;
    logic [23:0] w [8];
    logic [191:0] expS;
    logic leftLvl;
    n = 24; lj = 1'b0; mute = 1'b0;
    case (fmt)
      4'd0, 4'd1, 4'd2, 4'd3: n = 16 + 2 * int'(fmt[1:0]);
      4'd4, 4'd5, 4'd6, 4'd7: begin n = 16 + 2 * int'(fmt[1:0]); lj = 1'b1; end
      4'd12: n = 24;
      4'd13: lj = 1'b1;
      default: mute = 1'b1;
    endcase
    expS = '0;
    for (int ch = 0; ch < 8; ch++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      w[ch] = seed[27:4] >> (24 - n);
      expS[ch*24 +: 24] = mute ? 24'd0 : (w[ch] << (24 - n));
    end
    if (pendValid) begin
      expQ.push_back('{smp: pendSamples, usr: usr});
      tagQ.push_back(pendTag);
    end
    pendValid   = reportIt;
    pendSamples = expS;
    pendTag     = tag;
    leftLvl = ~startOnFall;
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        wordClk = (h == 0) ? leftLvl : ~leftLvl;
        fmtCode = fmt;
        userIn  = usr;
        for (int l = 0; l < 4; l++) begin
          int ch;
          logic b;
          ch = 2 * l + h;
          b  = (p[0] ^ l[0] ^ h[0]) | p[1];  // filler for unused positions
          if (lj && p < n)              b = w[ch][n - 1 - p];
          else if (!lj && p >= 32 - n)  b = w[ch][31 - p];
          dataIn[l] = b;
        end
      end
    end
  endtask

  // Closing edge for the last frame
  task automatic flushFrame(input logic [3:0] usr);
    if (pendValid) begin
      expQ.push_back('{smp: pendSamples, usr: usr});
      tagQ.push_back(pendTag);
    end
    pendValid = 1'b0;
    @(negedge clk);
    wordClk = ~startOnFall;
    userIn  = usr;
    repeat (12) @(negedge clk);
  endtask

  task automatic doReset(input logic pol);
    @(negedge clk);
    rst_n = 1'b0;
    startOnFall = pol;
    wordClk = 1'b0;
    dataIn = '0;
    userIn = '0;
    pendValid = 1'b0;
    wasValid = 1'b0;
    lastSamples = '0;
    lastUser = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8", "reset samples", samplesOut, '0);
    check("R8", "reset user", {188'd0, userOut}, '0);
    check("R8", "reset strobe", {191'd0, frameValid}, '0);
  endtask

  // Monitor: pops and compares as frames are reported
  always @(negedge clk) begin
    if (rst_n) begin
      if (wasValid) begin
        // R7: one-cycle strobe, outputs held
        check("R7", "strobe width", {191'd0, frameValid}, '0);
        check("R7", "samples held", samplesOut, lastSamples);
      end
      wasValid <= frameValid;
      if (frameValid) begin
        if (expQ.size() == 0) begin
          check("R8", "unexpected frame", {191'd0, frameValid}, '0);
        end else begin
          expItem_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          // R5: channel c of line c/2 at bits 24c+23..24c
          for (int ch = 0; ch < 8; ch++)
            check(t, $sformatf("R5 ch%0d", ch), {168'd0, samplesOut[ch*24 +: 24]},
                  {168'd0, e.smp[ch*24 +: 24]});
          check("R6", "user bits", {188'd0, userOut}, {188'd0, e.usr});
        end
        lastSamples <= samplesOut;
        lastUser    <= userOut;
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Rising edge opens frames
    doReset(1'b0);
    sendFrame(4'd0,  4'h1, 1'b1, "R1");
    sendFrame(4'd1,  4'h2, 1'b1, "R2");
    sendFrame(4'd2,  4'h3, 1'b1, "R9");
    sendFrame(4'd3,  4'h4, 1'b1, "R2");
    sendFrame(4'd4,  4'h5, 1'b1, "R1");
    sendFrame(4'd5,  4'h6, 1'b1, "R2");
    sendFrame(4'd6,  4'h7, 1'b1, "R9");
    sendFrame(4'd7,  4'h8, 1'b1, "R1");
    sendFrame(4'd12, 4'h9, 1'b1, "R1");
    sendFrame(4'd13, 4'hA, 1'b1, "R2");
    sendFrame(4'd15, 4'hB, 1'b1, "R3");
    sendFrame(4'd0,  4'hC, 1'b1, "R9");
    sendFrame(4'd9,  4'hD, 1'b1, "R3");
    sendFrame(4'd14, 4'hE, 1'b1, "R3");
    sendFrame(4'd11, 4'hF, 1'b1, "R3");
    sendFrame(4'd12, 4'h0, 1'b1, "R9");
    flushFrame(4'h5);
    check("R7", "frames outstanding", {160'd0, 32'(expQ.size())}, '0);

    // Falling edge opens frames; first frame has no opening edge and is dropped
    doReset(1'b1);
    sendFrame(4'd5,  4'h3, 1'b0, "R8");
    sendFrame(4'd13, 4'h6, 1'b1, "R4");
    sendFrame(4'd2,  4'h9, 1'b1, "R4");
    sendFrame(4'd7,  4'hC, 1'b1, "R4");
    flushFrame(4'hA);
    check("R4", "frames outstanding", {160'd0, 32'(expQ.size())}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule